// File: doc/BRIEF.md
# Vector Mask-to-Element Expansion Unit

This unit decodes one 32-bit instruction word and turns a small bit mask into a 128-bit vector. Each mask bit fills one vector element with all ones or with all zeros. The element size is 8, 16, 32, 64 or 128 bits. The mask comes from one of two places. The register forms take it from a 64-bit general-register operand. The immediate form gathers a 16-bit byte mask from three separate fields of the instruction word.

In the same cycle as the decode, the unit presents the index of the source register on `src_idx`, so that surrounding logic can fetch the 64-bit operand. On the next rising edge it registers three things: the expanded vector, the target register index and a valid flag. An instruction word that matches none of the six accepted patterns raises an illegal flag instead. In that case the previously registered vector and target index are left in place.

Top module: `vmask_expand_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `out_illegal`, `out_result` and `out_tgt` to zero.
- R2: A word accepted while `in_valid` is high produces its outputs one rising edge later: `out_valid`, the result, and `out_tgt` equal to insn[25:21]. A cycle with `in_valid` low raises neither output flag.
- R3: Register forms use insn[31:26]=000100, insn[10:0]=11001000010, the source index in insn[15:11] and the width selector in insn[20:16]. Selector 10000 selects byte elements: result byte k (k=0..15, counted from the least significant end) equals the operand bit k replicated. The low 64 bits use operand bits [7:0] and the high 64 bits use operand bits [15:8].
- R4: Selector 10001 selects halfword elements: halfword k takes operand bit k. The low half uses bits [3:0] and the high half uses bits [7:4].
- R5: Selector 10010 selects word elements: word k takes operand bit k. The low half uses bits [1:0] and the high half uses bits [3:2].
- R6: Selector 10011 selects doubleword elements: the low doubleword takes operand bit 0 and the high doubleword takes operand bit 1.
- R7: Selector 10100 replicates operand bit 0 across all 128 result bits.
- R8: Operand bits above those the selected width consumes have no effect on the result.
- R9: The immediate form is insn[31:26]=000100 with insn[5:1]=01010. Its byte mask, from bit 15 down to bit 0, is {insn[15:6], insn[20:16], insn[0]}. Mask bit k fills result byte k, so bits [15:8] fill the high doubleword and bits [7:0] fill the low one.
- R10: An accepted word that matches no form raises `out_illegal` (and not `out_valid`) one edge later, and leaves `out_result` and `out_tgt` unchanged.
- R11: `src_idx` equals insn[15:11] combinationally, in the same cycle.
- R12: `out_valid` and `out_illegal` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operand are sampled this cycle |
| insn | input | 32 | Instruction word |
| src_operand | input | 64 | General-register operand addressed by `src_idx` |
| src_idx | output | 5 | Source register index, decoded combinationally |
| out_valid | output | 1 | Registered result is from a legal word |
| out_illegal | output | 1 | Last sampled word matched no form |
| out_tgt | output | 5 | Registered target register index |
| out_result | output | 128 | Registered expanded vector |

## Verification
`src_idx` is combinational, so it is checked in the same cycle the word is driven. The flags, `out_tgt` and `out_result` are due exactly one rising edge after the word is sampled. The driver applies a new word (or an idle cycle) at each falling edge and queues the expected outcome for it. The monitor samples just after the next rising edge and takes one queued item per edge, so an output that arrives a cycle early or late shows up as a miscompare. For illegal words the expected item carries the vector and target held over from the last legal word.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

    typedef enum logic [2:0] {
        FILL_B8   = 3'd0,
        FILL_H16  = 3'd1,
        FILL_W32  = 3'd2,
        FILL_D64  = 3'd3,
        FILL_Q128 = 3'd4,
        FILL_IMM  = 3'd5
    } fill_kind_e;

    localparam logic [5:0]  OPC_PRIMARY  = 6'b000100;
    localparam logic [10:0] XO_REG_MASK  = 11'b11001000010;
    localparam logic [4:0]  XO_IMM_MASK  = 5'b01010;

    localparam logic [4:0]  SEL_BYTE     = 5'b10000;
    localparam logic [4:0]  SEL_HALF     = 5'b10001;
    localparam logic [4:0]  SEL_WORD     = 5'b10010;
    localparam logic [4:0]  SEL_DWORD    = 5'b10011;
    localparam logic [4:0]  SEL_QUAD     = 5'b10100;

endpackage

// File: rtl/vmx_decode.sv
module vmx_decode
    import vmx_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int IDX_W  = 5,
    parameter int IMM_W  = 16
) (
    input  logic [INSN_W-1:0] insn,
    output fill_kind_e        kind,
    output logic              legal,
    output logic [IDX_W-1:0]  tgt_idx,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IMM_W-1:0]  imm_mask
);

    assign tgt_idx  = insn[25:21];
    assign src_idx  = insn[15:11];
    // Byte mask gathered from three fields; field order is fixed by the encoding.
    assign imm_mask = {insn[15:6], insn[20:16], insn[0]};

    always_comb begin
        kind  = FILL_B8;
        legal = 1'b0;
        if (insn[31:26] == OPC_PRIMARY) begin
            if (insn[10:0] == XO_REG_MASK) begin
                unique case (insn[20:16])
                    SEL_BYTE:  begin kind = FILL_B8;   legal = 1'b1; end
                    SEL_HALF:  begin kind = FILL_H16;  legal = 1'b1; end
                    SEL_WORD:  begin kind = FILL_W32;  legal = 1'b1; end
                    SEL_DWORD: begin kind = FILL_D64;  legal = 1'b1; end
                    SEL_QUAD:  begin kind = FILL_Q128; legal = 1'b1; end
                    default:   begin kind = FILL_B8;   legal = 1'b0; end
                endcase
            end else if (insn[5:1] == XO_IMM_MASK) begin
                kind  = FILL_IMM;
                legal = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vmx_fill.sv
module vmx_fill
    import vmx_pkg::*;
#(
    parameter int MASK_W = 16,
    parameter int RES_W  = 128
) (
    input  fill_kind_e         kind,
    input  logic [MASK_W-1:0]  mask,
    output logic [RES_W-1:0]   result
);

    localparam int HALF_W  = RES_W / 2;
    localparam int N_SIZES = 4;

    logic [RES_W-1:0] cand [N_SIZES];

    // Element width 8<<n: each half holds HALF_W/EW elements, and the high
    // half continues the mask where the low half stopped.
    for (genvar n = 0; n < N_SIZES; n++) begin : g_size
        localparam int EW  = 8 << n;
        localparam int CNT = HALF_W / EW;
        for (genvar h = 0; h < 2; h++) begin : g_half
            for (genvar k = 0; k < CNT; k++) begin : g_elem
                assign cand[n][h*HALF_W + k*EW +: EW] = {EW{mask[h*CNT + k]}};
            end
        end
    end

    always_comb begin
        unique case (kind)
            FILL_B8, FILL_IMM: result = cand[0];
            FILL_H16:          result = cand[1];
            FILL_W32:          result = cand[2];
            FILL_D64:          result = cand[3];
            FILL_Q128:         result = {RES_W{mask[0]}};
            default:           result = '0;
        endcase
    end

endmodule

// File: rtl/vmask_expand_unit.sv
module vmask_expand_unit
    import vmx_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int GPR_W  = 64,
    parameter int IDX_W  = 5,
    parameter int RES_W  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [GPR_W-1:0]  src_operand,
    output logic [IDX_W-1:0]  src_idx,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [IDX_W-1:0]  out_tgt,
    output logic [RES_W-1:0]  out_result
);

    localparam int MASK_W = 16;

    fill_kind_e          dec_kind;
    logic                dec_legal;
    logic [IDX_W-1:0]    dec_tgt;
    logic [MASK_W-1:0]   dec_imm;
    logic [MASK_W-1:0]   fill_mask;
    logic [RES_W-1:0]    fill_result;
    logic                unused_hi_bits;

    vmx_decode #(.INSN_W(INSN_W), .IDX_W(IDX_W), .IMM_W(MASK_W)) u_decode (
        .insn     (insn),
        .kind     (dec_kind),
        .legal    (dec_legal),
        .tgt_idx  (dec_tgt),
        .src_idx  (src_idx),
        .imm_mask (dec_imm)
    );

    assign fill_mask      = (dec_kind == FILL_IMM) ? dec_imm : src_operand[MASK_W-1:0];
    assign unused_hi_bits = ^src_operand[GPR_W-1:MASK_W];

    vmx_fill #(.MASK_W(MASK_W), .RES_W(RES_W)) u_fill (
        .kind   (dec_kind),
        .mask   (fill_mask),
        .result (fill_result)
    );

    // Flag register.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid &  dec_legal;
            out_illegal <= in_valid & ~dec_legal;
        end
    end

    // Data register: only legal words overwrite it.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_tgt    <= '0;
        end else if (in_valid && dec_legal) begin
            out_result <= fill_result;
            out_tgt    <= dec_tgt;
        end
    end

endmodule

// File: rtl/vmx_expand_chk.sv
module vmx_expand_chk #(
    parameter int INSN_W = 32,
    parameter int GPR_W  = 64,
    parameter int IDX_W  = 5,
    parameter int RES_W  = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [INSN_W-1:0] insn,
    input logic [GPR_W-1:0]  src_operand,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [IDX_W-1:0]  out_tgt,
    input logic [RES_W-1:0]  out_result
);

    logic quad_form;
    assign quad_form = in_valid && insn[31:26] == 6'b000100 &&
                       insn[20:16] == 5'b10100 && insn[10:0] == 11'b11001000010;

    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    assert_out_follows_in_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid || out_illegal) |-> $past(in_valid));

    assert_tgt_capture_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_tgt == $past(insn[25:21]));

    assert_illegal_holds_R10: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> ($stable(out_result) && $stable(out_tgt)));

    assert_quad_uniform_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(quad_form)) |-> out_result == {RES_W{$past(src_operand[0])}});

endmodule

bind vmask_expand_unit vmx_expand_chk #(
    .INSN_W(INSN_W), .GPR_W(GPR_W), .IDX_W(IDX_W), .RES_W(RES_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .insn        (insn),
    .src_operand (src_operand),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_tgt     (out_tgt),
    .out_result  (out_result)
);

// File: tb/vmask_expand_unit_tb.sv
module vmask_expand_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [63:0]  src_operand = '0;
    logic [4:0]   src_idx;
    logic         out_valid;
    logic         out_illegal;
    logic [4:0]   out_tgt;
    logic [127:0] out_result;

    typedef struct {
        bit           vld;
        bit           ill;
        logic [127:0] res;
        logic [4:0]   tgt;
        string        req;
    } exp_item_t;

    exp_item_t    exp_q[$];
    int           n_checks = 0;
    int           n_fails  = 0;
    bit           done     = 1'b0;
    logic [127:0] hold_res = '0;
    logic [4:0]   hold_tgt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmask_expand_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .insn        (insn),
        .src_operand (src_operand),
        .src_idx     (src_idx),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_tgt     (out_tgt),
        .out_result  (out_result)
    );

    function automatic logic [31:0] reg_form(input logic [4:0] tgt, input logic [4:0] sel,
                                             input logic [4:0] src);
        return {6'b000100, tgt, sel, src, 11'b11001000010};
    endfunction

    function automatic logic [31:0] imm_form(input logic [4:0] tgt, input logic [15:0] m);
        return {6'b000100, tgt, m[5:1], m[15:6], 5'b01010, m[0]};
    endfunction

    // Element e of width ew takes mask bit e; quad form uses bit 0.
    function automatic logic [127:0] model(input logic [31:0] w, input logic [63:0] op,
                                           output bit ok);
        int           ew = 0;
        logic [63:0]  m  = op;
        logic [127:0] r  = '0;
        if (w[31:26] == 6'b000100) begin
            if (w[10:0] == 11'b11001000010) begin
                case (w[20:16])
                    5'b10000: ew = 8;
                    5'b10001: ew = 16;
                    5'b10010: ew = 32;
                    5'b10011: ew = 64;
                    5'b10100: ew = 128;
                    default:  ew = 0;
                endcase
            end else if (w[5:1] == 5'b01010) begin
                ew = 8;
                m  = {48'b0, w[15:6], w[20:16], w[0]};
            end
        end
        ok = (ew != 0);
        for (int i = 0; i < 128; i++) r[i] = ok ? m[i/ew] : 1'b0;
        return r;
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [31:0] w, input logic [63:0] op,
                         input string req);
        exp_item_t it;
        bit        ok;
        logic [127:0] r;
        @(negedge clk);
        in_valid    = v;
        insn        = w;
        src_operand = op;
        r = model(w, op, ok);
        if (v && ok) begin
            hold_res = r;
            hold_tgt = w[25:21];
        end
        it.vld = v && ok;
        it.ill = v && !ok;
        it.res = hold_res;
        it.tgt = hold_tgt;
        it.req = req;
        exp_q.push_back(it);
        #1;
        if (v) check(src_idx == w[15:11], "R11", "src_idx", 128'(src_idx), 128'(w[15:11]));
    endtask

    // Monitor: one queued outcome per rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst && exp_q.size() != 0) begin
            exp_item_t it;
            it = exp_q.pop_front();
            check(!(out_valid && out_illegal), "R12", "flags together",
                  {126'b0, out_valid, out_illegal}, 128'b0);
            check(out_valid == it.vld && out_illegal == it.ill, it.req, "flags",
                  {126'b0, out_valid, out_illegal}, {126'b0, it.vld, it.ill});
            check(out_result == it.res, it.req, "result", out_result, it.res);
            check(out_tgt == it.tgt, it.req, "target", 128'(out_tgt), 128'(it.tgt));
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_illegal == 1'b0, "R1", "reset flags",
              {126'b0, out_valid, out_illegal}, 128'b0);
        check(out_result == '0 && out_tgt == '0, "R1", "reset data", out_result, 128'b0);
        @(negedge clk);
        rst = 1'b0;

        drive(1'b1, reg_form(5'd3,  5'b10000, 5'd7),  64'hDEAD_BEEF_0000_A5C3, "R3");
        drive(1'b1, reg_form(5'd4,  5'b10001, 5'd9),  64'hFFFF_FFFF_FFFF_FF5A, "R4");
        drive(1'b1, reg_form(5'd5,  5'b10010, 5'd1),  64'h1234_5678_9ABC_DEF6, "R5");
        drive(1'b1, reg_form(5'd6,  5'b10011, 5'd2),  64'hFFFF_0000_0000_0002, "R6");
        drive(1'b0, reg_form(5'd9,  5'b10000, 5'd2),  64'hFFFF, "R2");
        drive(1'b1, reg_form(5'd7,  5'b10100, 5'd30), 64'h8000_0000_0000_0001, "R7");
        drive(1'b1, reg_form(5'd8,  5'b10100, 5'd31), 64'hFFFF_FFFF_FFFF_FFFE, "R8");
        drive(1'b1, reg_form(5'd10, 5'b10000, 5'd4),  64'hFFFF_FFFF_FFFF_0000, "R8");
        drive(1'b1, imm_form(5'd11, 16'h8001), 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        drive(1'b1, imm_form(5'd12, 16'h3E5C), 64'h0, "R9");
        drive(1'b1, {6'b000101, 5'd13, 5'b10000, 5'd0, 11'b11001000010}, 64'hFF, "R10");
        drive(1'b1, reg_form(5'd14, 5'b10101, 5'd0),  64'hFF, "R10");
        drive(1'b1, {6'b000100, 5'd15, 16'hFFFF, 5'b01011, 1'b1}, 64'h0, "R10");
        drive(1'b1, reg_form(5'd16, 5'b10011, 5'd5),  64'h1, "R2");
        drive(1'b1, imm_form(5'd17, 16'h00FF), 64'h0, "R2");
        drive(1'b0, 32'h0, 64'h0, "R2");

        @(posedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule